// File: doc/BRIEF.md
# Burst-Capable Pipelined Synchronous SRAM

This block is a synchronous static RAM with a 64-bit word, built as eight 8-bit lanes. Its depth is a parameter. Every control, address and write-data input is sampled on the rising clock edge. The sampled controls are decoded into one of five outcomes: deselect, burst start, burst continue, burst suspend, or no operation. Read data passes through an output pipeline register. Its visibility on the bus is gated by an asynchronous output enable.

A burst begins on one of two start strobes, and each has its own rule for choosing the operation. The processor start strobe always begins a read. The controller start strobe begins a write when a write is requested, and a read otherwise. After a burst has begun, an advance input steps a 2-bit burst counter. The counter walks the four words of the aligned group in either linear order or interleaved order. A sleep input parks the device: it accepts no operation and does not drive the bus.

The data bus is modelled as two separate directions. `dout_o` carries the read data. `drive_o` is the output-driver enable. When `drive_o` is low, the bus is in high-Z and `dout_o` reads zero.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `drive_o` is low and `dout_o` is zero until a read has been executed.
- R2: While `wr_byte_n_i` is low and `wr_all_n_i` is high, a write updates exactly the lanes whose `lane_n_i` bit is low. Bit k selects data bits 8k+7..8k. While `wr_byte_n_i` is high, `lane_n_i` has no effect and the operation is a read.
- R3: While `wr_all_n_i` is low, a write updates all eight lanes, whatever the values of `wr_byte_n_i` and `lane_n_i`.
- R4: An edge with the chip selected (`ce_n_i`=0, `ce2_i`=1, `ce3_n_i`=0) and `start_cpu_n_i`=0 starts a read at `addr_i`, even if write controls are active. Nothing is written at that edge.
- R5: An edge with `start_cpu_n_i`=1, `start_ctl_n_i`=0 and the chip selected starts a burst at `addr_i`. The burst is a write when a write is requested (`wr_all_n_i`=0, or `wr_byte_n_i`=0 with at least one `lane_n_i` bit low), and a read otherwise.
- R6: A start strobe sampled while any chip enable is inactive deselects the device and ends any burst. `start_cpu_n_i` is ignored while `ce_n_i` is high.
- R7: With both strobes inactive during a burst, `adv_n_i`=0 steps the burst. With `lin_i`=1, the low two address bits go base+1, base+2, base+3, modulo 4. The upper bits stay fixed.
- R8: With `lin_i`=0, the burst steps by XOR: the low two bits are base XOR count, for count 1, 2, 3.
- R9: With both strobes inactive and `adv_n_i`=1 during a burst, the address is held. The operation is a write if requested, and a read otherwise.
- R10: `oe_n_i` high forces `drive_o` low and `dout_o` to zero at once, without waiting for a clock edge.
- R11: While `sleep_i` is high, no operation is accepted, any burst ends, and `drive_o` is low.
- R12: Data for a read sampled at edge k is driven after edge k+1 and stays until edge k+2. A write sampled at edge k is visible to a read sampled at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_n_i | input | 1 | Chip enable, active low |
| start_cpu_n_i | input | 1 | Processor burst start strobe, active low |
| start_ctl_n_i | input | 1 | Controller burst start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| wr_all_n_i | input | 1 | Global write of all lanes, active low |
| wr_byte_n_i | input | 1 | Byte-write qualifier, active low |
| lane_n_i | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| din_i | input | LANES*LANE_W | Write data |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request, active high |
| dout_o | output | LANES*LANE_W | Read data, zero when not driven |
| drive_o | output | 1 | Bus driver enable, high while read data is driven |

## Verification
Some rules hold on every cycle, and the assertions check these. Output enable and sleep both block the driver at once. A deselecting strobe leaves the bus undriven two edges later. A processor-strobe start always ends with the bus driven, unless output enable is off. A controller-strobe write never drives the bus. Other behaviour can only be shown by the bench's scenarios, which compare read data against a reference array. These scenarios cover which lanes a write really changed, the linear and interleaved step orders, held addresses during suspend, the one-cycle output latency, and the fact that writes in sleep or under a processor strobe leave the storage unchanged.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_op_decode.sv
module sram_op_decode
  import sram_burst_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             ce_n_i,
  input  logic             ce2_i,
  input  logic             ce3_n_i,
  input  logic             start_cpu_n_i,
  input  logic             start_ctl_n_i,
  input  logic             adv_n_i,
  input  logic             wr_all_n_i,
  input  logic             wr_byte_n_i,
  input  logic [LANES-1:0] lane_n_i,
  input  logic             sleep_i,
  input  logic             active_i,
  output op_e              op_o,
  output logic             load_o,
  output logic             step_o,
  output logic             active_d_o,
  output logic [LANES-1:0] lane_we_o
);
  logic sel, wr_req;

  assign sel    = !ce_n_i && ce2_i && !ce3_n_i;
  assign wr_req = !wr_all_n_i || (!wr_byte_n_i && !(&lane_n_i));

  always_comb begin
    if (!wr_all_n_i)       lane_we_o = '1;
    else if (!wr_byte_n_i) lane_we_o = ~lane_n_i;
    else                   lane_we_o = '0;
  end

  always_comb begin
    op_o       = OP_IDLE;
    load_o     = 1'b0;
    step_o     = 1'b0;
    active_d_o = active_i;
    if (sleep_i) begin
      active_d_o = 1'b0;
    end else if (!ce_n_i && !start_cpu_n_i) begin
      // processor strobe always reads
      if (sel) begin
        op_o       = OP_READ;
        load_o     = 1'b1;
        active_d_o = 1'b1;
      end else begin
        active_d_o = 1'b0;
      end
    end else if (!start_ctl_n_i) begin
      if (sel) begin
        op_o       = wr_req ? OP_WRITE : OP_READ;
        load_o     = 1'b1;
        active_d_o = 1'b1;
      end else begin
        active_d_o = 1'b0;
      end
    end else if (active_i) begin
      op_o   = wr_req ? OP_WRITE : OP_READ;
      step_o = !adv_n_i;
    end
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr_o
);
  logic [ADDR_W-1:0]  cur_q;
  logic [BURST_W-1:0] base_q, cnt_q, cnt_nx, low_nx;

  assign cnt_nx = cnt_q + 1'b1;
  assign low_nx = lin_i ? (base_q + cnt_nx) : (base_q ^ cnt_nx);

  always_comb begin
    if (load_i)      eff_addr_o = addr_i;
    else if (step_i) eff_addr_o = {cur_q[ADDR_W-1:BURST_W], low_nx};
    else             eff_addr_o = cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      cur_q  <= addr_i;
      base_q <= addr_i[BURST_W-1:0];
      cnt_q  <= '0;
    end else if (step_i) begin
      cur_q  <= eff_addr_o;
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/sram_core.sv
module sram_core
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  op_e                     op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [LANES-1:0]        lane_we_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned DW    = LANES * LANE_W;

  // input register stage
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  lane_we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      lane_we_q <= '0;
    end else begin
      op_q      <= op_i;
      addr_q    <= addr_i;
      wdata_q   <= wdata_i;
      lane_we_q <= lane_we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= (op_q == OP_READ);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (op_q == OP_WRITE && lane_we_q[l])
        mem[addr_q] <= wdata_q[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                rd_q <= '0;
      else if (op_q == OP_READ)   rd_q <= mem[addr_q];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned LANES   = 8,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_n_i,
  input  logic                    ce2_i,
  input  logic                    ce3_n_i,
  input  logic                    start_cpu_n_i,
  input  logic                    start_ctl_n_i,
  input  logic                    adv_n_i,
  input  logic                    wr_all_n_i,
  input  logic                    wr_byte_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  input  logic                    lin_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    drive_o
);
  localparam int unsigned DW = LANES * LANE_W;

  op_e               op;
  logic              load, step, active_q, active_d, rvalid;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] eff_addr;
  logic [DW-1:0]     rdata;

  sram_op_decode #(.LANES(LANES)) u_dec (
    .ce_n_i        (ce_n_i),
    .ce2_i         (ce2_i),
    .ce3_n_i       (ce3_n_i),
    .start_cpu_n_i (start_cpu_n_i),
    .start_ctl_n_i (start_ctl_n_i),
    .adv_n_i       (adv_n_i),
    .wr_all_n_i    (wr_all_n_i),
    .wr_byte_n_i   (wr_byte_n_i),
    .lane_n_i      (lane_n_i),
    .sleep_i       (sleep_i),
    .active_i      (active_q),
    .op_o          (op),
    .load_o        (load),
    .step_o        (step),
    .active_d_o    (active_d),
    .lane_we_o     (lane_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  sram_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .lin_i      (lin_i),
    .addr_i     (addr_i),
    .eff_addr_o (eff_addr)
  );

  sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .addr_i    (eff_addr),
    .wdata_i   (din_i),
    .lane_we_i (lane_we),
    .rdata_o   (rdata),
    .rvalid_o  (rvalid)
  );

  // output enable and sleep gate the driver without a clock
  assign drive_o = rvalid && !oe_n_i && !sleep_i;
  assign dout_o  = drive_o ? rdata : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_n_i,
  input logic             ce2_i,
  input logic             ce3_n_i,
  input logic             start_cpu_n_i,
  input logic             start_ctl_n_i,
  input logic             wr_all_n_i,
  input logic             oe_n_i,
  input logic             sleep_i,
  input logic [DW-1:0]    dout_o,
  input logic             drive_o
);
  logic sel;
  assign sel = !ce_n_i && ce2_i && !ce3_n_i;

  AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> (!drive_o && dout_o == '0)); // R10

  AST_SLEEP_BLOCKS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !drive_o); // R11

  AST_DESEL_RELEASES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !ce_n_i && !start_cpu_n_i && !sel) |-> ##2 !drive_o); // R6

  AST_CPU_START_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sel && !start_cpu_n_i) |-> ##2 (drive_o || oe_n_i || sleep_i)); // R4

  AST_CTL_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sel && start_cpu_n_i && !start_ctl_n_i && !wr_all_n_i) |-> ##2 !drive_o); // R5

  AST_UNDRIVEN_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> dout_o == '0); // R1
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.LANES(LANES), .DW(LANES*LANE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ce_n_i        (ce_n_i),
  .ce2_i         (ce2_i),
  .ce3_n_i       (ce3_n_i),
  .start_cpu_n_i (start_cpu_n_i),
  .start_ctl_n_i (start_ctl_n_i),
  .wr_all_n_i    (wr_all_n_i),
  .oe_n_i        (oe_n_i),
  .sleep_i       (sleep_i),
  .dout_o        (dout_o),
  .drive_o       (drive_o)
);

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_n_i, ce2_i, ce3_n_i, start_cpu_n_i, start_ctl_n_i, adv_n_i;
  logic        wr_all_n_i, wr_byte_n_i, lin_i, oe_n_i, sleep_i;
  logic [7:0]  lane_n_i;
  logic [7:0]  addr_i;
  logic [63:0] din_i;
  logic [63:0] dout_o;
  logic        drive_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  logic [63:0] m [256];
  int          s1_op;
  logic [7:0]  s1_addr;
  logic [63:0] s1_data;
  logic [7:0]  s1_mask;
  bit          mrv, mact;
  logic [63:0] mdout;
  logic [7:0]  mcur;
  logic [1:0]  mbase, mcnt;

  always #5 clk_i = ~clk_i;

  sync_burst_sram dut_i (.*);

  task automatic idle_in();
    ce_n_i = 0; ce2_i = 1; ce3_n_i = 0;
    start_cpu_n_i = 1; start_ctl_n_i = 1; adv_n_i = 1;
    wr_all_n_i = 1; wr_byte_n_i = 1; lane_n_i = '1;
    oe_n_i = 0; sleep_i = 0;
  endtask

  task automatic check(string tag);
    bit          ed;
    logic [63:0] ev;
    ed = mrv && !oe_n_i && !sleep_i;
    ev = ed ? mdout : 64'd0;
    checks++;
    if (drive_o !== ed || dout_o !== ev) begin
      errors++;
      $display("FAIL %s: drive=%0b dout=%h expected drive=%0b dout=%h",
               tag, drive_o, dout_o, ed, ev);
    end
  endtask

  task automatic model_edge();
    bit         sel, wr, load, step;
    int         op;
    logic [1:0] nc, lo;
    logic [7:0] eff, mask;
    // output stage from previously sampled operation
    if (s1_op == 2)
      for (int l = 0; l < 8; l++)
        if (s1_mask[l]) m[s1_addr][l*8 +: 8] = s1_data[l*8 +: 8];
    if (s1_op == 1) begin mdout = m[s1_addr]; mrv = 1; end
    else mrv = 0;
    // decode newly sampled inputs
    sel  = !ce_n_i && ce2_i && !ce3_n_i;
    wr   = !wr_all_n_i || (!wr_byte_n_i && lane_n_i != 8'hff);
    mask = !wr_all_n_i ? 8'hff : (!wr_byte_n_i ? ~lane_n_i : 8'h00);
    op = 0; load = 0; step = 0;
    if (sleep_i) mact = 0;
    else if (!ce_n_i && !start_cpu_n_i) begin
      if (sel) begin op = 1; load = 1; mact = 1; end else mact = 0;
    end else if (!start_ctl_n_i) begin
      if (sel) begin op = wr ? 2 : 1; load = 1; mact = 1; end else mact = 0;
    end else if (mact) begin
      op = wr ? 2 : 1; step = !adv_n_i;
    end
    nc  = mcnt + 2'd1;
    lo  = lin_i ? mbase + nc : mbase ^ nc;
    eff = load ? addr_i : (step ? {mcur[7:2], lo} : mcur);
    if (load) begin mbase = addr_i[1:0]; mcnt = 0; mcur = addr_i; end
    else if (step) begin mcnt = nc; mcur = eff; end
    s1_op = op; s1_addr = eff; s1_data = din_i; s1_mask = mask;
  endtask

  task automatic tick(string tag);
    @(posedge clk_i);
    model_edge();
    #1;
    check(tag);
  endtask

  task automatic start_ctl_wr(input logic [7:0] a, input logic [63:0] d, string tag);
    idle_in(); start_ctl_n_i = 0; wr_all_n_i = 0; addr_i = a; din_i = d;
    tick(tag);
  endtask

  task automatic start_cpu_rd(input logic [7:0] a, string tag);
    idle_in(); start_cpu_n_i = 0; addr_i = a;
    tick(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle_in(); ce_n_i = 1; lin_i = 1; addr_i = 0; din_i = 0;
    s1_op = 0; mrv = 0; mact = 0; mdout = 0; mcur = 0; mbase = 0; mcnt = 0;
    s1_addr = 0; s1_data = 0; s1_mask = 0;
    #23 rst_ni = 1;
    #1 check("R1");
    tick("R1");

    // R3: global write fills the working region
    for (int a = 0; a < 16; a++)
      start_ctl_wr(a[7:0], {8{a[3:0], 4'h5}} ^ 64'h0123_4567_89ab_cdef, "R3");
    idle_in(); ce_n_i = 1; tick("R3");
    // R3: global write overrides disabled lane enables
    idle_in(); start_ctl_n_i = 0; wr_all_n_i = 0; wr_byte_n_i = 1; lane_n_i = '1;
    addr_i = 8'd1; din_i = 64'haaaa_bbbb_cccc_dddd; tick("R3");
    start_cpu_rd(8'd1, "R3"); idle_in(); ce_n_i = 1; tick("R3"); tick("R3");

    // R2: partial lane write, then lanes ignored when qualifier high
    idle_in(); start_ctl_n_i = 0; wr_byte_n_i = 0; lane_n_i = 8'b1010_1010;
    addr_i = 8'd3; din_i = '1; tick("R2");
    idle_in(); start_ctl_n_i = 0; wr_byte_n_i = 1; lane_n_i = 8'h00;
    addr_i = 8'd3; din_i = '0; tick("R2");
    idle_in(); ce_n_i = 1; tick("R2"); tick("R2");

    // R4: processor strobe with write controls still reads
    idle_in(); start_cpu_n_i = 0; start_ctl_n_i = 0; wr_all_n_i = 0;
    addr_i = 8'd7; din_i = 64'hdead_beef_dead_beef; tick("R4");
    idle_in(); ce_n_i = 1; tick("R12"); tick("R4");
    start_cpu_rd(8'd7, "R4"); idle_in(); ce_n_i = 1; tick("R4"); tick("R4");

    // R5 / R12: controller write then back-to-back read
    start_ctl_wr(8'd8, 64'h1111_2222_3333_4444, "R5");
    idle_in(); start_ctl_n_i = 0; addr_i = 8'd8; tick("R12");
    idle_in(); ce_n_i = 1; tick("R12"); tick("R5");

    // R7: linear write burst from 9, then linear read burst
    lin_i = 1;
    start_ctl_wr(8'd9, 64'h7000_0000_0000_0000, "R7");
    for (int i = 1; i < 4; i++) begin
      idle_in(); adv_n_i = 0; wr_all_n_i = 0; din_i = 64'h7000_0000_0000_0000 + i;
      tick("R7");
    end
    start_cpu_rd(8'd9, "R7");
    for (int i = 0; i < 4; i++) begin idle_in(); adv_n_i = 0; tick("R7"); end
    idle_in(); ce_n_i = 1; tick("R7");

    // R8: interleaved write burst from 14, then interleaved read
    lin_i = 0;
    start_ctl_wr(8'd14, 64'h8800_0000_0000_0000, "R8");
    for (int i = 1; i < 4; i++) begin
      idle_in(); adv_n_i = 0; wr_all_n_i = 0; din_i = 64'h8800_0000_0000_0000 + i;
      tick("R8");
    end
    start_cpu_rd(8'd14, "R8");
    for (int i = 0; i < 4; i++) begin idle_in(); adv_n_i = 0; tick("R8"); end
    lin_i = 1;

    // R9: suspend read and suspend write hold the address
    start_cpu_rd(8'd2, "R9");
    idle_in(); tick("R9"); tick("R9");
    idle_in(); wr_all_n_i = 0; din_i = 64'h9999_0000_9999_0000; tick("R9");
    idle_in(); tick("R9"); tick("R9"); tick("R9");

    // R6: deselect by inactive enable, processor strobe ignored with ce_n high
    idle_in(); start_cpu_n_i = 0; ce2_i = 0; tick("R6");
    idle_in(); ce_n_i = 1; tick("R6"); tick("R6");
    start_cpu_rd(8'd4, "R6");
    idle_in(); ce_n_i = 1; start_cpu_n_i = 0; adv_n_i = 0; tick("R6");
    idle_in(); ce_n_i = 1; start_cpu_n_i = 0; tick("R6");
    idle_in(); start_ctl_n_i = 0; ce3_n_i = 1; tick("R6"); tick("R6");

    // R10: asynchronous output enable
    start_cpu_rd(8'd5, "R10"); idle_in(); tick("R10");
    #1 oe_n_i = 1; #1 check("R10");
    #1 oe_n_i = 0; #1 check("R10");

    // R11: sleep blocks operations
    idle_in(); sleep_i = 1; start_ctl_n_i = 0; wr_all_n_i = 0;
    addr_i = 8'd0; din_i = '0; tick("R11");
    idle_in(); sleep_i = 1; tick("R11");
    start_cpu_rd(8'd0, "R11"); idle_in(); ce_n_i = 1; tick("R11"); tick("R11");

    // constrained random traffic within the prefilled region
    for (int n = 0; n < 600; n++) begin
      int k;
      idle_in();
      k = $urandom_range(0, 9);
      addr_i      = $urandom_range(0, 15);
      din_i       = {$urandom, $urandom};
      lin_i       = $urandom_range(0, 1);
      adv_n_i     = $urandom_range(0, 1);
      wr_all_n_i  = ($urandom_range(0, 3) != 0);
      wr_byte_n_i = $urandom_range(0, 1);
      lane_n_i    = $urandom;
      oe_n_i      = ($urandom_range(0, 7) == 0);
      sleep_i     = ($urandom_range(0, 15) == 0);
      case (k)
        0, 1: start_cpu_n_i = 0;
        2, 3: start_ctl_n_i = 0;
        4: begin start_cpu_n_i = 0; ce2_i = $urandom_range(0, 1); ce3_n_i = $urandom_range(0, 1); end
        5: begin start_ctl_n_i = 0; ce_n_i = 1; end
        6: begin ce_n_i = 1; start_cpu_n_i = 0; end
        default: ;
      endcase
      tick("R12");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule